// File: doc/BRIEF.md
# Blocking Two-Port Memory Request Forwarder

This block joins an instruction requester and a data requester to one memory-side port. Only one transaction can be outstanding at a time. A request that arrives while the block is idle is accepted and passed to the memory side in the same cycle, with its address, data and fetch flag unchanged. The block then stays busy until the memory side returns the response. A request that arrives while the block is busy is refused.

Flow control on every link is reject-and-retry. There is no ready/valid stall. When a receiver refuses a transfer, the sender keeps it in a single-entry holding register and sends it again only when the receiver pulses retry. A requester that was refused is owed a retry pulse. The block sends that pulse in a cycle in which a memory response arrives, provided the requester's response holding register will be empty after that cycle. The fetch flag carried by a response decides which requester receives it.

Top module: `mem_fwd`

## Requirements
- R1: While a transaction is outstanding and no response arrives, a request on either requester port gets a one-cycle reject pulse in the same cycle as the request. No request is forwarded in that cycle.
- R2: A refused requester records that it is owed a retry. A later one-cycle pulse on that port's retry output tells it to try again.
- R3: When idle, an accepted request appears on the memory-side request outputs in the same cycle, with address, data and fetch flag unchanged. The block then stays busy.
- R4: A memory response is presented to the instruction port in the cycle it arrives when its fetch flag is 1, and to the data port when the flag is 0. Address, data and flag pass through unchanged.
- R5: The cycle in which a memory response arrives counts as idle. A request presented in that cycle is accepted and forwarded.
- R6: In a response cycle, a port with a pending retry pulses its retry output only if its response holding register will be empty after that cycle. The pulse clears the pending flag, so it is not repeated.
- R7: A forwarded request refused by the memory side is held. It is presented again only in a cycle where the memory side pulses retry, and it may be refused again.
- R8: A response refused by a requester is held and presented again only when that requester pulses response retry. A response retry while nothing is held has no effect. Sending a new transfer into an occupied holding register is illegal and is flagged.
- R9: If both requesters ask in the same accepting cycle, the instruction port is accepted and the data port is refused and marked as owed a retry.
- R10: After reset the block is idle, no retry is owed, and every holding register is empty, so all valid, reject and retry outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ireq_vld_i | input | 1 | Instruction-port request valid |
| ireq_addr_i | input | AW | Instruction-port request address |
| ireq_data_i | input | DW | Instruction-port request data |
| ireq_fetch_i | input | 1 | Instruction-port request fetch flag |
| ireq_rej_o | output | 1 | Instruction-port request refused |
| ireq_retry_o | output | 1 | Instruction port may try again |
| irsp_vld_o | output | 1 | Instruction-port response valid |
| irsp_addr_o | output | AW | Instruction-port response address |
| irsp_data_o | output | DW | Instruction-port response data |
| irsp_fetch_o | output | 1 | Instruction-port response fetch flag |
| irsp_rej_i | input | 1 | Instruction requester refuses the response |
| irsp_retry_i | input | 1 | Instruction requester asks for the held response |
| dreq_vld_i | input | 1 | Data-port request valid |
| dreq_addr_i | input | AW | Data-port request address |
| dreq_data_i | input | DW | Data-port request data |
| dreq_fetch_i | input | 1 | Data-port request fetch flag |
| dreq_rej_o | output | 1 | Data-port request refused |
| dreq_retry_o | output | 1 | Data port may try again |
| drsp_vld_o | output | 1 | Data-port response valid |
| drsp_addr_o | output | AW | Data-port response address |
| drsp_data_o | output | DW | Data-port response data |
| drsp_fetch_o | output | 1 | Data-port response fetch flag |
| drsp_rej_i | input | 1 | Data requester refuses the response |
| drsp_retry_i | input | 1 | Data requester asks for the held response |
| mem_req_vld_o | output | 1 | Memory-side request valid |
| mem_req_addr_o | output | AW | Memory-side request address |
| mem_req_data_o | output | DW | Memory-side request data |
| mem_req_fetch_o | output | 1 | Memory-side request fetch flag |
| mem_req_rej_i | input | 1 | Memory side refuses the request |
| mem_req_retry_i | input | 1 | Memory side asks for the held request |
| mem_rsp_vld_i | input | 1 | Memory response valid |
| mem_rsp_addr_i | input | AW | Memory response address |
| mem_rsp_data_i | input | DW | Memory response data |
| mem_rsp_fetch_i | input | 1 | Memory response fetch flag, selects the target port |

## Verification
The assertions check on every cycle that the block turns busy after each acceptance and accepts nothing while busy without a response. They also check that memory responses and held memory requests occur only while a transaction is outstanding, that a refusal always fills the holding register with the refused payload, that a refused requester is marked as owed a retry, and that no transfer is pushed into an occupied holding register. Other behaviours only show up in the bench's scenarios. These are the same-cycle reuse after a response, the instruction-port priority, steering by the fetch flag, the retry pulse that is withheld while the response register stays full, and repeated refusal on the memory side.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NREQ   = 2;
  localparam int PORT_I = 0;
  localparam int PORT_D = 1;
endpackage

// File: rtl/fwd_hold_reg.sv
module fwd_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         send_vld_i,
  input  logic [W-1:0] send_pl_i,
  input  logic         rej_i,
  input  logic         retry_i,
  output logic         out_vld_o,
  output logic [W-1:0] out_pl_o,
  output logic         full_o
);
  logic         full_q;
  logic [W-1:0] pl_q;
  logic         resend;

  assign resend    = full_q & retry_i;
  assign out_vld_o = send_vld_i | resend;
  assign out_pl_o  = resend ? pl_q : send_pl_i;
  assign full_o    = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pl_q   <= '0;
    end else if (out_vld_o) begin
      full_q <= rej_i;
      if (rej_i) pl_q <= out_pl_o;
    end
  end

  // R8
  hold_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !send_vld_i);

  // R7
  refuse_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && rej_i) |=> (full_q && pl_q == $past(out_pl_o)));
endmodule

// File: rtl/fwd_req_port.sv
module fwd_req_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_rej_i,
  input  logic         rsp_evt_i,
  input  logic         rsp_send_i,
  input  logic [W-1:0] rsp_pl_i,
  input  logic         rsp_rej_i,
  input  logic         rsp_retry_i,
  output logic         rsp_vld_o,
  output logic [W-1:0] rsp_pl_o,
  output logic         req_retry_o
);
  logic pend_q;
  logic full;
  logic full_after;

  fwd_hold_reg #(.W(W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .send_vld_i (rsp_send_i),
    .send_pl_i  (rsp_pl_i),
    .rej_i      (rsp_rej_i),
    .retry_i    (rsp_retry_i),
    .out_vld_o  (rsp_vld_o),
    .out_pl_o   (rsp_pl_o),
    .full_o     (full)
  );

  // occupancy of the response register after this edge
  assign full_after  = (rsp_vld_o & rsp_rej_i) | (full & ~rsp_retry_i);
  assign req_retry_o = rsp_evt_i & pend_q & ~full_after;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= req_rej_i | (pend_q & ~req_retry_o);
  end

  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rej_i |=> pend_q);

  // R6
  retry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_retry_o && !req_rej_i) |=> !pend_q);
endmodule

// File: rtl/mem_fwd.sv
module mem_fwd
  import fwd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ireq_vld_i,
  input  logic [AW-1:0] ireq_addr_i,
  input  logic [DW-1:0] ireq_data_i,
  input  logic          ireq_fetch_i,
  output logic          ireq_rej_o,
  output logic          ireq_retry_o,
  output logic          irsp_vld_o,
  output logic [AW-1:0] irsp_addr_o,
  output logic [DW-1:0] irsp_data_o,
  output logic          irsp_fetch_o,
  input  logic          irsp_rej_i,
  input  logic          irsp_retry_i,
  input  logic          dreq_vld_i,
  input  logic [AW-1:0] dreq_addr_i,
  input  logic [DW-1:0] dreq_data_i,
  input  logic          dreq_fetch_i,
  output logic          dreq_rej_o,
  output logic          dreq_retry_o,
  output logic          drsp_vld_o,
  output logic [AW-1:0] drsp_addr_o,
  output logic [DW-1:0] drsp_data_o,
  output logic          drsp_fetch_o,
  input  logic          drsp_rej_i,
  input  logic          drsp_retry_i,
  output logic          mem_req_vld_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_data_o,
  output logic          mem_req_fetch_o,
  input  logic          mem_req_rej_i,
  input  logic          mem_req_retry_i,
  input  logic          mem_rsp_vld_i,
  input  logic [AW-1:0] mem_rsp_addr_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  input  logic          mem_rsp_fetch_i
);
  localparam int PW = AW + DW + 1;

  logic [NREQ-1:0] req_vld, req_rej, acc;
  logic [NREQ-1:0] rsp_vld, rsp_rej, rsp_retry, req_retry;
  logic [PW-1:0]   req_pl [NREQ];
  logic [PW-1:0]   rsp_pl [NREQ];
  logic [PW-1:0]   fwd_pl, mem_pl, mem_rsp_pl;
  logic            busy_q, can_acc, taken, mem_full;

  assign req_vld[PORT_I]   = ireq_vld_i;
  assign req_vld[PORT_D]   = dreq_vld_i;
  assign req_pl[PORT_I]    = {ireq_fetch_i, ireq_addr_i, ireq_data_i};
  assign req_pl[PORT_D]    = {dreq_fetch_i, dreq_addr_i, dreq_data_i};
  assign rsp_rej[PORT_I]   = irsp_rej_i;
  assign rsp_rej[PORT_D]   = drsp_rej_i;
  assign rsp_retry[PORT_I] = irsp_retry_i;
  assign rsp_retry[PORT_D] = drsp_retry_i;
  assign mem_rsp_pl        = {mem_rsp_fetch_i, mem_rsp_addr_i, mem_rsp_data_i};

  // response cycle frees the block before routing
  assign can_acc = ~busy_q | mem_rsp_vld_i;

  // fixed priority, lowest index (instruction) first
  always_comb begin
    acc    = '0;
    fwd_pl = '0;
    taken  = ~can_acc;
    for (int p = 0; p < NREQ; p++) begin
      if (req_vld[p] && !taken) begin
        acc[p] = 1'b1;
        fwd_pl = req_pl[p];
        taken  = 1'b1;
      end
    end
  end

  assign req_rej = req_vld & ~acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= 1'b0;
    else if (|acc)          busy_q <= 1'b1;
    else if (mem_rsp_vld_i) busy_q <= 1'b0;
  end

  fwd_hold_reg #(.W(PW)) u_mem_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .send_vld_i (|acc),
    .send_pl_i  (fwd_pl),
    .rej_i      (mem_req_rej_i),
    .retry_i    (mem_req_retry_i),
    .out_vld_o  (mem_req_vld_o),
    .out_pl_o   (mem_pl),
    .full_o     (mem_full)
  );

  assign {mem_req_fetch_o, mem_req_addr_o, mem_req_data_o} = mem_pl;

  for (genvar p = 0; p < NREQ; p++) begin : g_port
    logic steer;
    assign steer = (p == PORT_I) ? mem_rsp_fetch_i : ~mem_rsp_fetch_i;

    fwd_req_port #(.W(PW)) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_rej_i   (req_rej[p]),
      .rsp_evt_i   (mem_rsp_vld_i),
      .rsp_send_i  (mem_rsp_vld_i & steer),
      .rsp_pl_i    (mem_rsp_pl),
      .rsp_rej_i   (rsp_rej[p]),
      .rsp_retry_i (rsp_retry[p]),
      .rsp_vld_o   (rsp_vld[p]),
      .rsp_pl_o    (rsp_pl[p]),
      .req_retry_o (req_retry[p])
    );
  end

  assign ireq_rej_o   = req_rej[PORT_I];
  assign dreq_rej_o   = req_rej[PORT_D];
  assign ireq_retry_o = req_retry[PORT_I];
  assign dreq_retry_o = req_retry[PORT_D];
  assign irsp_vld_o   = rsp_vld[PORT_I];
  assign drsp_vld_o   = rsp_vld[PORT_D];
  assign {irsp_fetch_o, irsp_addr_o, irsp_data_o} = rsp_pl[PORT_I];
  assign {drsp_fetch_o, drsp_addr_o, drsp_data_o} = rsp_pl[PORT_D];

  // R3
  acc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc) |=> busy_q);

  // R1
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !mem_rsp_vld_i) |-> !mem_req_vld_o || mem_full);

  // R5
  rsp_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_vld_i |-> busy_q);

  // R7
  mem_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_full |-> busy_q);
endmodule

// File: tb/mem_fwd_bench.sv
`timescale 1ns/1ps
module mem_fwd_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PW = AW + DW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ireq_vld, ireq_fetch, ireq_rej, ireq_retry;
  logic [AW-1:0] ireq_addr;
  logic [DW-1:0] ireq_data;
  logic          irsp_vld, irsp_fetch, irsp_rej, irsp_retry;
  logic [AW-1:0] irsp_addr;
  logic [DW-1:0] irsp_data;
  logic          dreq_vld, dreq_fetch, dreq_rej, dreq_retry;
  logic [AW-1:0] dreq_addr;
  logic [DW-1:0] dreq_data;
  logic          drsp_vld, drsp_fetch, drsp_rej, drsp_retry;
  logic [AW-1:0] drsp_addr;
  logic [DW-1:0] drsp_data;
  logic          mreq_vld, mreq_fetch, mreq_rej, mreq_retry;
  logic [AW-1:0] mreq_addr;
  logic [DW-1:0] mreq_data;
  logic          mrsp_vld, mrsp_fetch;
  logic [AW-1:0] mrsp_addr;
  logic [DW-1:0] mrsp_data;

  mem_fwd #(.AW(AW), .DW(DW)) u_mem_fwd (
    .clk_i(clk), .rst_ni(rst_n),
    .ireq_vld_i(ireq_vld), .ireq_addr_i(ireq_addr), .ireq_data_i(ireq_data),
    .ireq_fetch_i(ireq_fetch), .ireq_rej_o(ireq_rej), .ireq_retry_o(ireq_retry),
    .irsp_vld_o(irsp_vld), .irsp_addr_o(irsp_addr), .irsp_data_o(irsp_data),
    .irsp_fetch_o(irsp_fetch), .irsp_rej_i(irsp_rej), .irsp_retry_i(irsp_retry),
    .dreq_vld_i(dreq_vld), .dreq_addr_i(dreq_addr), .dreq_data_i(dreq_data),
    .dreq_fetch_i(dreq_fetch), .dreq_rej_o(dreq_rej), .dreq_retry_o(dreq_retry),
    .drsp_vld_o(drsp_vld), .drsp_addr_o(drsp_addr), .drsp_data_o(drsp_data),
    .drsp_fetch_o(drsp_fetch), .drsp_rej_i(drsp_rej), .drsp_retry_i(drsp_retry),
    .mem_req_vld_o(mreq_vld), .mem_req_addr_o(mreq_addr), .mem_req_data_o(mreq_data),
    .mem_req_fetch_o(mreq_fetch), .mem_req_rej_i(mreq_rej), .mem_req_retry_i(mreq_retry),
    .mem_rsp_vld_i(mrsp_vld), .mem_rsp_addr_i(mrsp_addr), .mem_rsp_data_i(mrsp_data),
    .mem_rsp_fetch_i(mrsp_fetch)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [PW-1:0] mq[$];
  logic [PW-1:0] iq[$];
  logic [PW-1:0] dq[$];

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    ireq_vld = 0; dreq_vld = 0; mrsp_vld = 0;
    mreq_rej = 0; mreq_retry = 0;
    irsp_rej = 0; irsp_retry = 0; drsp_rej = 0; drsp_retry = 0;
  endtask

  task automatic send_i(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f, input bit exp_acc);
    ireq_vld = 1; ireq_addr = a; ireq_data = d; ireq_fetch = f;
    if (exp_acc) mq.push_back({f, a, d});
  endtask

  task automatic send_d(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f, input bit exp_acc);
    dreq_vld = 1; dreq_addr = a; dreq_data = d; dreq_fetch = f;
    if (exp_acc) mq.push_back({f, a, d});
  endtask

  task automatic mem_resp(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f);
    mrsp_vld = 1; mrsp_addr = a; mrsp_data = d; mrsp_fetch = f;
    if (f) iq.push_back({f, a, d});
    else   dq.push_back({f, a, d});
  endtask

  // scoreboard monitor: compare every presented item, pop when not refused
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (mreq_vld) begin
        if (mq.size() == 0) chk("R3 unexpected mem request", PW'(1), PW'(0));
        else begin
          chk("R3 mem request fields", {mreq_fetch, mreq_addr, mreq_data}, mq[0]);
          if (!mreq_rej) void'(mq.pop_front());
        end
      end
      if (irsp_vld) begin
        if (iq.size() == 0) chk("R4 unexpected inst response", PW'(1), PW'(0));
        else begin
          chk("R4 inst response fields", {irsp_fetch, irsp_addr, irsp_data}, iq[0]);
          if (!irsp_rej) void'(iq.pop_front());
        end
      end
      if (drsp_vld) begin
        if (dq.size() == 0) chk("R4 unexpected data response", PW'(1), PW'(0));
        else begin
          chk("R4 data response fields", {drsp_fetch, drsp_addr, drsp_data}, dq[0]);
          if (!drsp_rej) void'(dq.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    ireq_addr = '0; ireq_data = '0; ireq_fetch = 0;
    dreq_addr = '0; dreq_data = '0; dreq_fetch = 0;
    mrsp_addr = '0; mrsp_data = '0; mrsp_fetch = 0;
    cyc(); cyc(); cyc();
    rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 outputs idle", PW'({ireq_rej, dreq_rej, ireq_retry, dreq_retry, irsp_vld, drsp_vld, mreq_vld}), PW'(0));
    cyc(); #1;
    chk("R10 still idle", PW'({irsp_vld, drsp_vld, mreq_vld}), PW'(0));

    cyc(); send_i(32'h100, 32'hA1, 1, 1); #1;
    chk("R3 accept no reject", PW'(ireq_rej), PW'(0));
    chk("R3 forwarded same cycle", PW'(mreq_vld), PW'(1));

    cyc(); send_d(32'h300, 32'hB1, 0, 0); send_i(32'h104, 32'hB2, 1, 0); #1;
    chk("R1 data refused while busy", PW'(dreq_rej), PW'(1));
    chk("R1 inst refused while busy", PW'(ireq_rej), PW'(1));
    chk("R1 nothing forwarded", PW'(mreq_vld), PW'(0));

    cyc(); #1;
    chk("R1 reject is one cycle", PW'({ireq_rej, dreq_rej}), PW'(0));
    chk("R2 no early retry", PW'({ireq_retry, dreq_retry}), PW'(0));

    cyc(); mem_resp(32'h100, 32'h5A, 1); #1;
    chk("R2 inst retry pulse", PW'(ireq_retry), PW'(1));
    chk("R2 data retry pulse", PW'(dreq_retry), PW'(1));
    chk("R4 fetch response not on data port", PW'(drsp_vld), PW'(0));

    cyc(); #1;
    chk("R6 retry not repeated", PW'({ireq_retry, dreq_retry}), PW'(0));

    cyc(); send_i(32'h200, 32'hC1, 1, 1); send_d(32'h204, 32'hC2, 0, 0); #1;
    chk("R9 inst wins", PW'(ireq_rej), PW'(0));
    chk("R9 data refused", PW'(dreq_rej), PW'(1));

    cyc(); mem_resp(32'h200, 32'h77, 1); send_i(32'h400, 32'hC3, 1, 1); #1;
    chk("R5 accept in response cycle", PW'(ireq_rej), PW'(0));
    chk("R5 forwarded in response cycle", PW'(mreq_vld), PW'(1));
    chk("R6 data owed retry", PW'(dreq_retry), PW'(1));
    chk("R6 inst not owed retry", PW'(ireq_retry), PW'(0));

    cyc(); send_d(32'h500, 32'hC4, 0, 0); #1;
    chk("R5 busy again after reuse", PW'(dreq_rej), PW'(1));

    cyc(); mem_resp(32'h400, 32'h88, 0); #1;
    chk("R4 flag 0 routes to data", PW'(drsp_vld), PW'(1));
    chk("R4 flag 0 not to inst", PW'(irsp_vld), PW'(0));
    chk("R6 data retry after response", PW'(dreq_retry), PW'(1));

    cyc(); send_d(32'h600, 32'hD6, 0, 1); mreq_rej = 1; #1;
    chk("R7 requester accepted", PW'(dreq_rej), PW'(0));
    chk("R7 first attempt presented", PW'(mreq_vld), PW'(1));

    cyc(); #1;
    chk("R7 no resend without retry", PW'(mreq_vld), PW'(0));

    cyc(); mreq_retry = 1; mreq_rej = 1; #1;
    chk("R7 resend on retry", PW'(mreq_vld), PW'(1));

    cyc(); mreq_retry = 1; #1;
    chk("R7 resend after second refusal", PW'(mreq_vld), PW'(1));

    cyc(); #1;
    chk("R7 hold emptied", PW'(mreq_vld), PW'(0));

    cyc(); send_d(32'h700, 32'hE1, 0, 0); #1;
    chk("R1 refused while memory pending", PW'(dreq_rej), PW'(1));

    cyc(); mem_resp(32'h600, 32'h66, 0); drsp_rej = 1; #1;
    chk("R8 response presented", PW'(drsp_vld), PW'(1));
    chk("R6 retry withheld while hold full", PW'(dreq_retry), PW'(0));

    cyc(); irsp_retry = 1; #1;
    chk("R8 held response not resent", PW'(drsp_vld), PW'(0));
    chk("R8 retry on empty hold ignored", PW'(irsp_vld), PW'(0));

    cyc(); drsp_retry = 1; #1;
    chk("R8 held response resent", PW'(drsp_vld), PW'(1));
    chk("R6 no retry without response", PW'(dreq_retry), PW'(0));

    cyc(); #1;
    chk("R8 hold emptied", PW'(drsp_vld), PW'(0));
    chk("R3 all requests seen", PW'(mq.size()), PW'(0));
    chk("R4 all responses seen", PW'(iq.size() + dq.size()), PW'(0));

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule